// File: doc/BRIEF.md
# Horizontal Line Timing Generator

The block produces the horizontal timing of one scan line for a display controller that can drive a CRT monitor, a TFT panel or a passive LCD panel. A pixel-clock position counter walks through an active-display region and then a blanking region. A line-sync pulse is placed inside the blanking region. The same pulse feeds two pins: a CRT sync output and a panel line-pulse output. Each pin has its own polarity bit.

All lengths are programmed in 8-pixel units. The active width, blanking length, sync delay and sync width come in on plain configuration inputs. These inputs are captured once per line, on the clock edge where the counter returns to pixel 0. The control core is a four-state machine:
- `ST_ACTIVE`: pixels are shown.
- `ST_LEAD`: blanking before the pulse.
- `ST_SYNC`: the pulse is asserted.
- `ST_TAIL`: blanking after the pulse.

The transitions are:
- `ACTIVE->LEAD` when the active width is used up.
- `LEAD->SYNC` when the sync delay has elapsed.
- `SYNC->TAIL` when the pulse width or the blanking end is reached.
- A wrap to `ACTIVE` from any blanking state on the last pixel of the line.

Top module: `hsync_timing_gen`

## Requirements
- R1: The line lasts (A+1)*8 + (N+1)*8 clocks, where A is `cfg_active_units` and N is `cfg_blank_units`. `line_start_o` is high for exactly one clock, at pixel 0 of each line.
- R2: `disp_en_o` is high for pixels 0 to (A+1)*8-1 of the line and low for the rest of the line.
- R3: The sync pulse starts (D+1)*8 pixels after the first blanking pixel, where D is `cfg_sync_delay`.
- R4: For panel code 0 (CRT) and code 1 (TFT), the pulse lasts (W+1)*8 pixels, where W is `cfg_sync_width`. Panel code 3 behaves like TFT.
- R5: For panel code 2 (passive), the pulse lasts exactly 8 pixels and W has no effect.
- R6: The pulse is cut off at the last blanking pixel and is never asserted during active display. When D >= N, no pulse appears.
- R7: When `cfg_crt_pol` is 1, `crt_sync_o` is high while the pulse is asserted. When `cfg_crt_pol` is 0, it is low while the pulse is asserted. At all other times it holds the opposite level.
- R8: For panel codes other than 2, `line_pulse_o` behaves like `crt_sync_o` but follows `cfg_line_pol`.
- R9: For panel code 2, the meaning of `cfg_line_pol` is inverted: a value of 1 makes the pulse active low, and a value of 0 makes it active high.
- R10: A configuration change during a line has no effect until the next line starts.
- R11: While `rst_n` is low, and on the first cycle after it rises, the block is at pixel 0. In that state `disp_en_o` = 1, `line_start_o` = 1, and both sync pins are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_active_units | input | ACT_W | Active width, (value+1)*8 pixels |
| cfg_blank_units | input | BLK_W | Blanking length, (value+1)*8 pixels |
| cfg_sync_delay | input | DLY_W | Blanking start to pulse start, (value+1)*8 pixels |
| cfg_sync_width | input | PW_W | Pulse width, (value+1)*8 pixels (non-passive) |
| cfg_crt_pol | input | 1 | CRT sync polarity |
| cfg_line_pol | input | 1 | Panel line-pulse polarity |
| cfg_panel | input | 2 | 0 CRT, 1 TFT, 2 passive, 3 as TFT |
| crt_sync_o | output | 1 | CRT horizontal sync |
| line_pulse_o | output | 1 | Panel line pulse |
| disp_en_o | output | 1 | Active-display enable |
| line_start_o | output | 1 | Pixel-0 strobe |

## Verification
The bench targets these corner cases and the faults they expose:
- **Pulse cut at the blanking end** (delay plus width larger than blanking, including the widest blanking). A design without the cut would let the pulse run into the next line's active pixels.
- **Delay that reaches or passes the blanking length.** A design that mishandled it would show a stray pulse.
- **Passive mode.** A design that ignored the mode would take the programmed width instead of 8 pixels, or keep the TFT polarity meaning.
- **Configuration written in mid-line.** A design that skipped the per-line capture would change the current line's length or pulse position at once.

Every one of these runs against a pixel-by-pixel arithmetic model over a sweep of blanking, delay, width, panel type and polarity.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    typedef enum logic [1:0] {
        PANEL_CRT     = 2'd0,
        PANEL_TFT     = 2'd1,
        PANEL_PASSIVE = 2'd2,
        PANEL_SPARE   = 2'd3
    } panel_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LEAD   = 2'd1,
        ST_SYNC   = 2'd2,
        ST_TAIL   = 2'd3
    } hstate_e;

endpackage

// File: rtl/hsync_cfg_stage.sv
module hsync_cfg_stage
    import hsync_pkg::*;
#(
    parameter int ACT_W      = 6,
    parameter int BLK_W      = 5,
    parameter int DLY_W      = 5,
    parameter int PW_W       = 4,
    parameter int UNIT_SHIFT = 3,
    parameter int AUTO_UNITS = 1,
    parameter int LINE_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_wrap_i,
    input  logic [ACT_W-1:0]  act_units_i,
    input  logic [BLK_W-1:0]  blk_units_i,
    input  logic [DLY_W-1:0]  dly_units_i,
    input  logic [PW_W-1:0]   pw_units_i,
    input  logic              crt_pol_i,
    input  logic              line_pol_i,
    input  logic [1:0]        panel_i,
    output logic [LINE_W-1:0] act_end_o,
    output logic [LINE_W-1:0] sync_on_o,
    output logic [LINE_W-1:0] sync_off_o,
    output logic [LINE_W-1:0] line_len_o,
    output logic              crt_pol_nxt_o,
    output logic              line_pol_nxt_o,
    output logic              passive_nxt_o
);

    localparam logic [LINE_W-1:0] ONE     = LINE_W'(1);
    localparam logic [LINE_W-1:0] AUTO_PX = LINE_W'(AUTO_UNITS) << UNIT_SHIFT;

    logic              load;
    logic [ACT_W-1:0]  act_q;
    logic [BLK_W-1:0]  blk_q;
    logic [DLY_W-1:0]  dly_q;
    logic [PW_W-1:0]   pw_q;
    logic              crt_pol_q;
    logic              line_pol_q;
    panel_e            panel_q;
    panel_e            panel_in;

    logic [LINE_W-1:0] act_px, blk_px, dly_px, pw_px, off_raw;

    assign load     = line_wrap_i | ~rst_n;
    assign panel_in = panel_e'(panel_i);

    // Capture once per line (and during reset)
    always_ff @(posedge clk) begin
        if (load) begin
            act_q      <= act_units_i;
            blk_q      <= blk_units_i;
            dly_q      <= dly_units_i;
            pw_q       <= pw_units_i;
            crt_pol_q  <= crt_pol_i;
            line_pol_q <= line_pol_i;
            panel_q    <= panel_in;
        end
    end

    always_comb begin
        act_px = (LINE_W'(act_q) + ONE) << UNIT_SHIFT;
        blk_px = (LINE_W'(blk_q) + ONE) << UNIT_SHIFT;
        dly_px = (LINE_W'(dly_q) + ONE) << UNIT_SHIFT;
        if (panel_q == PANEL_PASSIVE) begin
            pw_px = AUTO_PX;
        end else begin
            pw_px = (LINE_W'(pw_q) + ONE) << UNIT_SHIFT;
        end
        act_end_o  = act_px;
        line_len_o = act_px + blk_px;
        sync_on_o  = act_px + dly_px;
        off_raw    = sync_on_o + pw_px;
        sync_off_o = (off_raw > line_len_o) ? line_len_o : off_raw;
    end

    // Values that will govern the next pixel
    always_comb begin
        crt_pol_nxt_o  = load ? crt_pol_i  : crt_pol_q;
        line_pol_nxt_o = load ? line_pol_i : line_pol_q;
        passive_nxt_o  = load ? (panel_in == PANEL_PASSIVE) : (panel_q == PANEL_PASSIVE);
    end

    // R10: captured configuration only moves at a line boundary
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wrap_i |=> $stable({act_q, blk_q, dly_q, pw_q, crt_pol_q, line_pol_q, panel_q}));

endmodule

// File: rtl/hsync_line_fsm.sv
module hsync_line_fsm
    import hsync_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] act_end_i,
    input  logic [LINE_W-1:0] sync_on_i,
    input  logic [LINE_W-1:0] sync_off_i,
    input  logic [LINE_W-1:0] line_len_i,
    output logic              line_wrap_o,
    output hstate_e           state_nxt_o,
    output logic              first_px_nxt_o
);

    localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

    logic [LINE_W-1:0] pos_q, pos_nxt;
    hstate_e           state_q, state_nxt;

    always_comb begin
        line_wrap_o = (pos_q == line_len_i - ONE);
        if (!rst_n || line_wrap_o) begin
            pos_nxt = '0;
        end else begin
            pos_nxt = pos_q + ONE;
        end
    end

    always_comb begin
        state_nxt = state_q;
        if (!rst_n || line_wrap_o) begin
            state_nxt = ST_ACTIVE;
        end else begin
            unique case (state_q)
                ST_ACTIVE: if (pos_nxt == act_end_i)  state_nxt = ST_LEAD;
                ST_LEAD:   if (pos_nxt == sync_on_i)  state_nxt = ST_SYNC;
                ST_SYNC:   if (pos_nxt == sync_off_i) state_nxt = ST_TAIL;
                ST_TAIL:   state_nxt = ST_TAIL;
                default:   state_nxt = ST_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        pos_q   <= pos_nxt;
        state_q <= state_nxt;
    end

    assign state_nxt_o    = state_nxt;
    assign first_px_nxt_o = (pos_nxt == '0);

    // R1: last pixel of the line is followed by pixel 0
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == line_len_i - ONE) |=> (pos_q == '0));

    // R2: active state only covers the active pixels
    a_r2_active_span: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |-> (pos_q < act_end_i));

    // R3/R4: pulse state lies between its start and end positions
    a_r4_sync_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> (pos_q >= sync_on_i && pos_q < sync_off_i));

    // R6: pulse never lasts past the blanking end
    a_r6_sync_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> (pos_q < line_len_i));

endmodule

// File: rtl/hsync_pin_stage.sv
module hsync_pin_stage
    import hsync_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  hstate_e state_nxt_i,
    input  logic    first_px_nxt_i,
    input  logic    crt_pol_i,
    input  logic    line_pol_i,
    input  logic    passive_i,
    output logic    crt_sync_o,
    output logic    line_pulse_o,
    output logic    disp_en_o,
    output logic    line_start_o
);

    logic pulse_nxt;
    logic crt_nxt, line_nxt;
    logic crt_pol_q;

    always_comb begin
        pulse_nxt = (state_nxt_i == ST_SYNC);
        crt_nxt   = crt_pol_i ? pulse_nxt : ~pulse_nxt;
        if (passive_i) begin
            line_nxt = line_pol_i ? ~pulse_nxt : pulse_nxt;
        end else begin
            line_nxt = line_pol_i ? pulse_nxt : ~pulse_nxt;
        end
    end

    always_ff @(posedge clk) begin
        crt_sync_o   <= crt_nxt;
        line_pulse_o <= line_nxt;
        disp_en_o    <= (state_nxt_i == ST_ACTIVE);
        line_start_o <= first_px_nxt_i;
        crt_pol_q    <= crt_pol_i;
    end

    // R6: no pulse on the CRT pin during active display
    a_r6_quiet_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en_o |-> (crt_sync_o == ~crt_pol_q));

    // R1: the line strobe falls inside active display
    a_r1_start_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> disp_en_o);

endmodule

// File: rtl/hsync_timing_gen.sv
module hsync_timing_gen
    import hsync_pkg::*;
#(
    parameter int ACT_W      = 6,
    parameter int BLK_W      = 5,
    parameter int DLY_W      = 5,
    parameter int PW_W       = 4,
    parameter int UNIT_SHIFT = 3,
    parameter int AUTO_UNITS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACT_W-1:0] cfg_active_units,
    input  logic [BLK_W-1:0] cfg_blank_units,
    input  logic [DLY_W-1:0] cfg_sync_delay,
    input  logic [PW_W-1:0]  cfg_sync_width,
    input  logic             cfg_crt_pol,
    input  logic             cfg_line_pol,
    input  logic [1:0]       cfg_panel,
    output logic             crt_sync_o,
    output logic             line_pulse_o,
    output logic             disp_en_o,
    output logic             line_start_o
);

    localparam int WIDEST = (ACT_W > BLK_W) ? ACT_W : BLK_W;
    localparam int LINE_W = WIDEST + UNIT_SHIFT + 2;

    logic [LINE_W-1:0] act_end, sync_on, sync_off, line_len;
    logic              line_wrap;
    logic              crt_pol_nxt, line_pol_nxt, passive_nxt;
    hstate_e           state_nxt;
    logic              first_px_nxt;

    hsync_cfg_stage #(
        .ACT_W(ACT_W), .BLK_W(BLK_W), .DLY_W(DLY_W), .PW_W(PW_W),
        .UNIT_SHIFT(UNIT_SHIFT), .AUTO_UNITS(AUTO_UNITS), .LINE_W(LINE_W)
    ) u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_wrap_i    (line_wrap),
        .act_units_i    (cfg_active_units),
        .blk_units_i    (cfg_blank_units),
        .dly_units_i    (cfg_sync_delay),
        .pw_units_i     (cfg_sync_width),
        .crt_pol_i      (cfg_crt_pol),
        .line_pol_i     (cfg_line_pol),
        .panel_i        (cfg_panel),
        .act_end_o      (act_end),
        .sync_on_o      (sync_on),
        .sync_off_o     (sync_off),
        .line_len_o     (line_len),
        .crt_pol_nxt_o  (crt_pol_nxt),
        .line_pol_nxt_o (line_pol_nxt),
        .passive_nxt_o  (passive_nxt)
    );

    hsync_line_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .act_end_i      (act_end),
        .sync_on_i      (sync_on),
        .sync_off_i     (sync_off),
        .line_len_i     (line_len),
        .line_wrap_o    (line_wrap),
        .state_nxt_o    (state_nxt),
        .first_px_nxt_o (first_px_nxt)
    );

    hsync_pin_stage u_pins (
        .clk            (clk),
        .rst_n          (rst_n),
        .state_nxt_i    (state_nxt),
        .first_px_nxt_i (first_px_nxt),
        .crt_pol_i      (crt_pol_nxt),
        .line_pol_i     (line_pol_nxt),
        .passive_i      (passive_nxt),
        .crt_sync_o     (crt_sync_o),
        .line_pulse_o   (line_pulse_o),
        .disp_en_o      (disp_en_o),
        .line_start_o   (line_start_o)
    );

endmodule

// File: tb/hsync_timing_gen_tb.sv
module hsync_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_active_units = '0;
    logic [4:0] cfg_blank_units = '0;
    logic [4:0] cfg_sync_delay = '0;
    logic [3:0] cfg_sync_width = '0;
    logic       cfg_crt_pol = 1'b0;
    logic       cfg_line_pol = 1'b0;
    logic [1:0] cfg_panel = '0;
    logic       crt_sync_o, line_pulse_o, disp_en_o, line_start_o;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    // Independent pixel model: position plus per-line captured settings
    int mp = 0;
    int ma, mn, ms, mw, mcp, mlp, mty;

    always #10 clk = ~clk;

    hsync_timing_gen u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_active_units (cfg_active_units), .cfg_blank_units (cfg_blank_units),
        .cfg_sync_delay (cfg_sync_delay), .cfg_sync_width (cfg_sync_width),
        .cfg_crt_pol (cfg_crt_pol), .cfg_line_pol (cfg_line_pol), .cfg_panel (cfg_panel),
        .crt_sync_o (crt_sync_o), .line_pulse_o (line_pulse_o),
        .disp_en_o (disp_en_o), .line_start_o (line_start_o)
    );

    function automatic int line_len_model();
        return (ma + 1) * 8 + (mn + 1) * 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || mp == line_len_model() - 1) begin
            mp  <= 0;
            ma  <= int'(cfg_active_units);
            mn  <= int'(cfg_blank_units);
            ms  <= int'(cfg_sync_delay);
            mw  <= int'(cfg_sync_width);
            mcp <= int'(cfg_crt_pol);
            mlp <= int'(cfg_line_pol);
            mty <= int'(cfg_panel);
            model_on <= 1'b1;
        end else begin
            mp <= mp + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !done) begin
            int ae, st, w, b;
            bit act;
            ae  = (ma + 1) * 8;
            st  = (ms + 1) * 8;
            w   = (mty == 2) ? 8 : (mw + 1) * 8;
            b   = mp - ae;
            act = (mp >= ae) && (b >= st) && (b < st + w) && (b < (mn + 1) * 8);
            chk("R1 line_start", int'(line_start_o), int'(mp == 0));
            chk("R2 disp_en", int'(disp_en_o), int'(mp < ae));
            chk("R7 crt_sync", int'(crt_sync_o), mcp != 0 ? int'(act) : int'(!act));
            if (mty == 2)
                chk("R9 line_pulse passive", int'(line_pulse_o), mlp != 0 ? int'(!act) : int'(act));
            else
                chk("R8 line_pulse", int'(line_pulse_o), mlp != 0 ? int'(act) : int'(!act));
        end
    end

    task automatic set_cfg(input int a, input int n, input int s, input int w,
                           input int ty, input bit cp, input bit lp);
        cfg_active_units = 6'(a);
        cfg_blank_units  = 5'(n);
        cfg_sync_delay   = 5'(s);
        cfg_sync_width   = 4'(w);
        cfg_panel        = 2'(ty);
        cfg_crt_pol      = cp;
        cfg_line_pol     = lp;
    endtask

    task automatic wait_ls();
        do @(negedge clk); while (!line_start_o);
    endtask

    // Called at a line start: measures one whole line at the pins
    task automatic measure(output int period, output int de_cnt, output int first,
                           output int len, output int line_low);
        int i;
        period = 0; de_cnt = 0; first = -1; len = 0; line_low = 0; i = 0;
        do begin
            if (disp_en_o) de_cnt++;
            if (crt_sync_o == cfg_crt_pol) begin
                if (first < 0) first = i;
                len++;
            end
            if (!line_pulse_o) line_low++;
            i++;
            @(negedge clk);
        end while (!line_start_o);
        period = i;
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_sim();
        end
    end

    initial begin
        int p, d, f, l, lo;
        int wl[4] = '{0, 1, 3, 15};
        int idx;
        // R11: reset state
        set_cfg(2, 4, 1, 1, 1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 disp_en in reset", int'(disp_en_o), 1);
        chk("R11 line_start in reset", int'(line_start_o), 1);
        chk("R11 crt inactive", int'(crt_sync_o), 0);
        chk("R11 line inactive", int'(line_pulse_o), 0);
        rst_n = 1'b1;

        // R3 R4 R8: TFT, active-low line pulse
        set_cfg(2, 4, 1, 1, 1, 1'b1, 1'b0);
        wait_ls();
        measure(p, d, f, l, lo);
        chk("R1 period", p, 64);
        chk("R2 active count", d, 24);
        chk("R3 pulse start", f, 40);
        chk("R4 pulse width", l, 16);
        chk("R8 tft low count", lo, 16);

        // R5 R9: passive ignores width, pol=1 is active low
        set_cfg(1, 5, 0, 7, 2, 1'b1, 1'b1);
        wait_ls();
        measure(p, d, f, l, lo);
        chk("R3 passive start", f, 24);
        chk("R5 passive width", l, 8);
        chk("R9 passive low count", lo, 8);

        // R6: truncation at blanking end
        set_cfg(0, 3, 1, 15, 0, 1'b0, 1'b1);
        wait_ls();
        measure(p, d, f, l, lo);
        chk("R6 truncated start", f, 24);
        chk("R6 truncated width", l, 16);
        chk("R1 period short", p, 40);

        // R6: widest blanking, pulse clipped to 8
        set_cfg(0, 31, 30, 3, 1, 1'b1, 1'b1);
        wait_ls();
        measure(p, d, f, l, lo);
        chk("R1 period max blank", p, 264);
        chk("R6 clipped width", l, 8);

        // R6: delay reaches blanking length, no pulse
        set_cfg(0, 2, 2, 0, 0, 1'b1, 1'b1);
        wait_ls();
        measure(p, d, f, l, lo);
        chk("R6 no pulse", l, 0);

        // R10: mid-line change keeps current line
        set_cfg(0, 3, 1, 15, 0, 1'b1, 1'b1);
        wait_ls();
        wait_ls();
        p = 0;
        do begin
            p++;
            if (p == 5) set_cfg(3, 3, 0, 0, 1, 1'b1, 1'b1);
            @(negedge clk);
        end while (!line_start_o);
        chk("R10 old period kept", p, 40);
        measure(p, d, f, l, lo);
        chk("R10 new period", p, 64);

        // Sweep checked pixel by pixel against the model
        idx = 0;
        for (int ty = 0; ty < 3; ty++)
            for (int n = 0; n < 8; n++)
                for (int s = 0; s <= n + 1; s++)
                    for (int wi = 0; wi < 4; wi++) begin
                        set_cfg((n + s) % 3, n, s, wl[wi], ty, idx[0], idx[1]);
                        idx++;
                        wait_ls();
                    end
        wait_ls();
        finish_sim();
    end

endmodule